// File: doc/BRIEF.md
# Radio Frame Buffer Controller

This block holds the transmit and receive packet buffers of a low-rate radio transceiver and connects them to a byte-wide host register port. The host fills the transmit buffer with a header-length byte, a frame-length byte and the payload. It then writes a launch register, and the block streams the frame out on a valid/ready byte interface to the modulator side. The launch value can also mark the frame as needing an acknowledgement, and that mark travels with the outgoing bytes.

On the receive side, bytes from the demodulator arrive one per cycle whenever `rx_valid` is high. The first byte of a frame is its payload length. The payload follows, then a link-quality byte and a signal-strength byte. The block stores the whole frame in the receive buffer in that layout and raises a receive-done event. The host can set an inhibit bit so that no arriving frame overwrites the buffer while software is reading it.

Transmit-done and receive-done events are collected in a status register that clears when read. Each event has its own mask bit, and any unmasked pending event pulls the active-low interrupt output down.

Top module: `radio_fbuf`

## Requirements
- R1: After reset, `irq_n` is 1, `tx_valid` is 0, the status register (0x201) reads 0x00, the mask register (0x202) reads 0x09 (both events masked) and the receive-control register (0x203) reads 0x00.
- R2: The transmit buffer occupies host addresses 0x000-0x07F and can be written and read back. The receive buffer occupies 0x100-0x18F and is read-only: host writes there change nothing. Read data appears on `host_rdata` one cycle after the `host_rd` strobe.
- R3: A write to 0x200 with bit 0 set starts a frame while the transmitter is idle. The output carries the frame-length byte taken from transmit byte 1, then that many payload bytes starting at transmit byte 2, one byte per cycle in which `tx_valid` and `tx_ready` are both high. `tx_last` marks the final byte. Bit 2 of the launch value is shown on `tx_ackreq` for the whole frame. The final handshake sets status bit 0.
- R4: A frame-length byte above 126 is treated as 126, both in the streamed length byte and in the number of payload bytes sent.
- R5: A launch write is ignored when bit 0 of the written value is clear, and also while a frame is still being sent.
- R6: While `tx_valid` is high and `tx_ready` is low, `tx_valid`, `tx_data` and `tx_last` keep their values into the next cycle.
- R7: For a received frame with length L, the buffer holds L at index 0, the payload at indices 1..L, the link-quality byte at index L+1 and the signal-strength byte at index L+2. Storing the signal-strength byte sets status bit 3.
- R8: While bit 2 of 0x203 is set, arriving bytes are not written to the receive buffer. A frame with any byte arriving in that state does not set status bit 3.
- R9: A received length above 141 drops the frame. The L+2 bytes that follow are consumed without being stored and no status is set, and the next byte is taken as a new length.
- R10: Reading 0x201 returns bit 0 (transmit done) and bit 3 (receive done) and clears both. An event in the same cycle as that read is absent from the returned value but remains set afterwards.
- R11: `irq_n` is 0 exactly when a status bit is set whose mask bit in 0x202 (bit 0 for transmit done, bit 3 for receive done) is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| host_wr | input | 1 | Host write strobe |
| host_rd | input | 1 | Host read strobe |
| host_addr | input | 10 | Host byte address |
| host_wdata | input | 8 | Host write data |
| host_rdata | output | 8 | Host read data, valid the cycle after the strobe |
| tx_valid | output | 1 | Outgoing byte valid |
| tx_ready | input | 1 | Downstream accepts the byte |
| tx_data | output | 8 | Outgoing byte |
| tx_last | output | 1 | Final byte of the frame |
| tx_ackreq | output | 1 | Frame requests acknowledgement |
| rx_valid | input | 1 | Incoming byte valid |
| rx_data | input | 8 | Incoming byte |
| irq_n | output | 1 | Active-low interrupt |

## Verification
Two sources set status bits, and the host read clears them, so the risk lies in cycles where these overlap. The bench places the final receive byte in the same cycle as a status read. It then expects the read to return zero while the interrupt still goes low and a second read returns 0x08. A separate scenario holds back `tx_ready` on the last byte of a zero-length frame and releases it in the same cycle as the final receive byte. One status read must then show 0x09, proving that neither event overwrote the other.

// File: rtl/fbuf_pkg.sv
`timescale 1ns/1ps
package fbuf_pkg;

    localparam int HOST_AW        = 10;
    localparam int BYTE_W         = 8;

    localparam int TXBUF_DEPTH    = 128;
    localparam int RXBUF_DEPTH    = 144;
    localparam int TX_HDR_BYTES   = 2;   // header-length slot, frame-length slot
    localparam int RX_TRAIL_BYTES = 2;   // link quality, signal strength

    // host map; the transmit window starts at zero
    localparam logic [HOST_AW-1:0] RXBUF_BASE = 10'h100;
    localparam logic [HOST_AW-1:0] REG_LAUNCH = 10'h200;
    localparam logic [HOST_AW-1:0] REG_STATUS = 10'h201;
    localparam logic [HOST_AW-1:0] REG_MASK   = 10'h202;
    localparam logic [HOST_AW-1:0] REG_RXCTL  = 10'h203;

    localparam int LAUNCH_GO_BIT     = 0;
    localparam int LAUNCH_ACK_BIT    = 2;
    localparam int ST_TXDONE_BIT     = 0;
    localparam int ST_RXDONE_BIT     = 3;
    localparam int RXCTL_INHIBIT_BIT = 2;

    typedef logic [BYTE_W-1:0] byte_t;

    localparam byte_t MASK_RESET = 8'h09;

    typedef enum logic [1:0] {
        TX_IDLE,
        TX_LEN,
        TX_BODY
    } tx_state_e;

    typedef enum logic [1:0] {
        RX_WAIT_LEN,
        RX_BODY
    } rx_state_e;

    typedef struct packed {
        logic go;
        logic ackreq;
    } launch_t;

    typedef struct packed {
        logic tx_done;
        logic rx_done;
    } event_t;

    function automatic byte_t cap_byte(input byte_t raw, input byte_t limit);
        return (raw > limit) ? limit : raw;
    endfunction

endpackage

// File: rtl/fbuf_tx_engine.sv
`timescale 1ns/1ps
module fbuf_tx_engine
    import fbuf_pkg::*;
#(
    parameter int DEPTH = TXBUF_DEPTH,
    localparam int IDX_W = $clog2(DEPTH)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             wr_en,
    input  logic [IDX_W-1:0] wr_idx,
    input  byte_t            wr_data,
    input  logic [IDX_W-1:0] rd_idx,
    output byte_t            rd_data,
    input  launch_t          launch,
    output logic             tx_valid,
    input  logic             tx_ready,
    output byte_t            tx_data,
    output logic             tx_last,
    output logic             tx_ackreq,
    output logic             done,
    output logic             len_phase
);
    localparam int PAY_MAX = DEPTH - TX_HDR_BYTES;
    localparam byte_t PAY_MAX_B = byte_t'(PAY_MAX);
    localparam logic [IDX_W-1:0] LEN_SLOT  = IDX_W'(1);
    localparam logic [IDX_W-1:0] FIRST_PAY = IDX_W'(TX_HDR_BYTES);

    byte_t            mem [DEPTH];
    tx_state_e        st_q;
    byte_t            len_q;
    byte_t            rem_q;
    logic [IDX_W-1:0] idx_q;
    logic             ack_q;
    logic             fire;
    byte_t            cap_len;

    always_ff @(posedge clk) begin
        if (wr_en) begin
            mem[wr_idx] <= wr_data;
        end
    end

    assign rd_data = mem[rd_idx];
    assign cap_len = cap_byte(mem[LEN_SLOT], PAY_MAX_B);
    assign fire    = tx_valid && tx_ready;

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q  <= TX_IDLE;
            len_q <= '0;
            rem_q <= '0;
            idx_q <= '0;
            ack_q <= 1'b0;
        end else begin
            case (st_q)
                TX_IDLE: begin
                    if (launch.go) begin
                        st_q  <= TX_LEN;
                        len_q <= cap_len;
                        rem_q <= cap_len;
                        idx_q <= FIRST_PAY;
                        ack_q <= launch.ackreq;
                    end
                end
                TX_LEN: begin
                    if (fire) begin
                        st_q <= (len_q == '0) ? TX_IDLE : TX_BODY;
                    end
                end
                TX_BODY: begin
                    if (fire) begin
                        idx_q <= idx_q + 1'b1;
                        rem_q <= rem_q - 1'b1;
                        if (rem_q == 8'd1) begin
                            st_q <= TX_IDLE;
                        end
                    end
                end
                default: st_q <= TX_IDLE;
            endcase
        end
    end

    always_comb begin
        tx_valid = (st_q != TX_IDLE);
        tx_data  = (st_q == TX_LEN) ? len_q : mem[idx_q];
        if (st_q == TX_LEN) begin
            tx_last = (len_q == '0);
        end else begin
            tx_last = (st_q == TX_BODY) && (rem_q == 8'd1);
        end
    end

    assign tx_ackreq = ack_q && tx_valid;
    assign done      = fire && tx_last;
    assign len_phase = (st_q == TX_LEN);

endmodule

// File: rtl/fbuf_rx_engine.sv
`timescale 1ns/1ps
module fbuf_rx_engine
    import fbuf_pkg::*;
#(
    parameter int DEPTH = RXBUF_DEPTH,
    localparam int IDX_W = $clog2(DEPTH)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             rx_valid,
    input  byte_t            rx_data,
    input  logic             inhibit,
    input  logic [IDX_W-1:0] rd_idx,
    output byte_t            rd_data,
    output logic             done
);
    // position counter must reach a full length byte plus the trailer
    localparam int POS_W = BYTE_W + 1;
    localparam int PAY_MAX = DEPTH - 1 - RX_TRAIL_BYTES;
    localparam byte_t PAY_MAX_B = byte_t'(PAY_MAX);
    localparam logic [POS_W-1:0] TRAIL = POS_W'(RX_TRAIL_BYTES);

    byte_t            mem [DEPTH];
    rx_state_e        st_q;
    byte_t            len_q;
    logic [POS_W-1:0] pos_q;
    logic             keep_q;
    logic             we;
    logic [IDX_W-1:0] widx;
    logic             len_ok;
    logic             final_byte;

    always_comb begin
        len_ok     = (rx_data <= PAY_MAX_B);
        final_byte = (st_q == RX_BODY) && (pos_q == ({1'b0, len_q} + TRAIL));
        we         = 1'b0;
        widx       = '0;
        if (rx_valid && !inhibit) begin
            if (st_q == RX_WAIT_LEN) begin
                we = len_ok;
            end else begin
                we   = keep_q;
                widx = pos_q[IDX_W-1:0];
            end
        end
        done = rx_valid && final_byte && keep_q && !inhibit;
    end

    always_ff @(posedge clk) begin
        if (we) begin
            mem[widx] <= rx_data;
        end
    end

    assign rd_data = mem[rd_idx];

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q   <= RX_WAIT_LEN;
            len_q  <= '0;
            pos_q  <= '0;
            keep_q <= 1'b0;
        end else if (rx_valid) begin
            case (st_q)
                RX_WAIT_LEN: begin
                    len_q  <= rx_data;
                    pos_q  <= POS_W'(1);
                    keep_q <= len_ok && !inhibit;
                    st_q   <= RX_BODY;
                end
                RX_BODY: begin
                    keep_q <= keep_q && !inhibit;
                    if (final_byte) begin
                        st_q <= RX_WAIT_LEN;
                    end else begin
                        pos_q <= pos_q + 1'b1;
                    end
                end
                default: st_q <= RX_WAIT_LEN;
            endcase
        end
    end

endmodule

// File: rtl/fbuf_ctl_regs.sv
`timescale 1ns/1ps
module fbuf_ctl_regs
    import fbuf_pkg::*;
(
    input  logic               clk,
    input  logic               rst,
    input  logic               wr_en,
    input  logic               rd_en,
    input  logic [HOST_AW-1:0] addr,
    input  byte_t              wdata,
    input  event_t             events,
    output launch_t            launch,
    output logic               rx_inhibit,
    output byte_t              status,
    output byte_t              reg_rdata,
    output logic               irq_n
);
    byte_t mask_q;
    byte_t rxctl_q;
    byte_t status_q;
    byte_t status_d;
    logic  status_rd;

    // a read clears first, then new events are merged so they survive
    always_comb begin
        status_rd = rd_en && (addr == REG_STATUS);
        status_d  = status_rd ? '0 : status_q;
        if (events.tx_done) begin
            status_d[ST_TXDONE_BIT] = 1'b1;
        end
        if (events.rx_done) begin
            status_d[ST_RXDONE_BIT] = 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            mask_q   <= MASK_RESET;
            rxctl_q  <= '0;
            status_q <= '0;
        end else begin
            status_q <= status_d;
            if (wr_en && (addr == REG_MASK)) begin
                mask_q <= wdata;
            end
            if (wr_en && (addr == REG_RXCTL)) begin
                rxctl_q <= wdata;
            end
        end
    end

    always_comb begin
        launch.go     = wr_en && (addr == REG_LAUNCH) && wdata[LAUNCH_GO_BIT];
        launch.ackreq = wdata[LAUNCH_ACK_BIT];
    end

    always_comb begin
        case (addr)
            REG_STATUS: reg_rdata = status_q;
            REG_MASK:   reg_rdata = mask_q;
            REG_RXCTL:  reg_rdata = rxctl_q;
            default:    reg_rdata = '0;
        endcase
    end

    assign rx_inhibit = rxctl_q[RXCTL_INHIBIT_BIT];
    assign status     = status_q;
    assign irq_n      = ~|(status_q & ~mask_q);

endmodule

// File: rtl/radio_fbuf.sv
`timescale 1ns/1ps
module radio_fbuf
    import fbuf_pkg::*;
#(
    parameter int TX_DEPTH = TXBUF_DEPTH,
    parameter int RX_DEPTH = RXBUF_DEPTH
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         host_wr,
    input  logic         host_rd,
    input  logic [9:0]   host_addr,
    input  logic [7:0]   host_wdata,
    output logic [7:0]   host_rdata,
    output logic         tx_valid,
    input  logic         tx_ready,
    output logic [7:0]   tx_data,
    output logic         tx_last,
    output logic         tx_ackreq,
    input  logic         rx_valid,
    input  logic [7:0]   rx_data,
    output logic         irq_n
);
    localparam int TX_IDX_W = $clog2(TX_DEPTH);
    localparam int RX_IDX_W = $clog2(RX_DEPTH);
    localparam logic [HOST_AW-1:0] TX_END = HOST_AW'(TX_DEPTH);
    localparam logic [HOST_AW-1:0] RX_END = HOST_AW'(int'(RXBUF_BASE) + RX_DEPTH);

    logic                in_tx;
    logic                in_rx;
    logic [TX_IDX_W-1:0] tx_idx;
    logic [RX_IDX_W-1:0] rx_idx;
    byte_t               tx_rd;
    byte_t               rx_rd;
    byte_t               reg_rd;
    launch_t             launch_w;
    event_t              events_w;
    logic                tx_done_w;
    logic                rx_done_w;
    logic                rx_inhibit_w;
    logic                tx_len_phase_w;
    byte_t               irq_status_w;

    assign in_tx  = (host_addr < TX_END);
    assign in_rx  = (host_addr >= RXBUF_BASE) && (host_addr < RX_END);
    assign tx_idx = host_addr[TX_IDX_W-1:0];
    assign rx_idx = in_rx ? RX_IDX_W'(host_addr - RXBUF_BASE) : '0;

    fbuf_tx_engine #(
        .DEPTH (TX_DEPTH)
    ) u_tx (
        .clk       (clk),
        .rst       (rst),
        .wr_en     (host_wr && in_tx),
        .wr_idx    (tx_idx),
        .wr_data   (host_wdata),
        .rd_idx    (tx_idx),
        .rd_data   (tx_rd),
        .launch    (launch_w),
        .tx_valid  (tx_valid),
        .tx_ready  (tx_ready),
        .tx_data   (tx_data),
        .tx_last   (tx_last),
        .tx_ackreq (tx_ackreq),
        .done      (tx_done_w),
        .len_phase (tx_len_phase_w)
    );

    fbuf_rx_engine #(
        .DEPTH (RX_DEPTH)
    ) u_rx (
        .clk      (clk),
        .rst      (rst),
        .rx_valid (rx_valid),
        .rx_data  (rx_data),
        .inhibit  (rx_inhibit_w),
        .rd_idx   (rx_idx),
        .rd_data  (rx_rd),
        .done     (rx_done_w)
    );

    assign events_w.tx_done = tx_done_w;
    assign events_w.rx_done = rx_done_w;

    fbuf_ctl_regs u_regs (
        .clk        (clk),
        .rst        (rst),
        .wr_en      (host_wr),
        .rd_en      (host_rd),
        .addr       (host_addr),
        .wdata      (host_wdata),
        .events     (events_w),
        .launch     (launch_w),
        .rx_inhibit (rx_inhibit_w),
        .status     (irq_status_w),
        .reg_rdata  (reg_rd),
        .irq_n      (irq_n)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            host_rdata <= '0;
        end else if (host_rd) begin
            if (in_tx) begin
                host_rdata <= tx_rd;
            end else if (in_rx) begin
                host_rdata <= rx_rd;
            end else begin
                host_rdata <= reg_rd;
            end
        end
    end

endmodule

// File: rtl/radio_fbuf_chk.sv
`timescale 1ns/1ps
module radio_fbuf_chk
    import fbuf_pkg::*;
(
    input logic               clk,
    input logic               rst,
    input logic               host_rd,
    input logic [HOST_AW-1:0] host_addr,
    input logic               tx_valid,
    input logic               tx_ready,
    input logic [7:0]         tx_data,
    input logic               tx_last,
    input logic               irq_n,
    input logic               tx_done,
    input logic               rx_done,
    input logic               rx_inhibit,
    input logic [7:0]         status,
    input logic               tx_len_phase
);
    localparam byte_t TX_CAP = byte_t'(TXBUF_DEPTH - TX_HDR_BYTES);

    AST_TX_HOLD: assert property (@(posedge clk) disable iff (rst)
        (tx_valid && !tx_ready) |=> (tx_valid && $stable(tx_data) && $stable(tx_last))); // R6

    AST_TX_LEN_CAP: assert property (@(posedge clk) disable iff (rst)
        (tx_valid && tx_len_phase) |-> (tx_data <= TX_CAP)); // R4

    AST_TX_DONE_FLAG: assert property (@(posedge clk) disable iff (rst)
        (tx_valid && tx_ready && tx_last) |=> status[ST_TXDONE_BIT]); // R3

    AST_RX_INHIBIT_QUIET: assert property (@(posedge clk) disable iff (rst)
        rx_inhibit |-> !rx_done); // R8

    AST_STATUS_CLEARED: assert property (@(posedge clk) disable iff (rst)
        (host_rd && (host_addr == REG_STATUS) && !tx_done && !rx_done) |=> (status == 8'h00)); // R10

    AST_IRQ_IDLE: assert property (@(posedge clk) disable iff (rst)
        (status == 8'h00) |-> irq_n); // R11

endmodule

bind radio_fbuf radio_fbuf_chk u_chk (
    .clk          (clk),
    .rst          (rst),
    .host_rd      (host_rd),
    .host_addr    (host_addr),
    .tx_valid     (tx_valid),
    .tx_ready     (tx_ready),
    .tx_data      (tx_data),
    .tx_last      (tx_last),
    .irq_n        (irq_n),
    .tx_done      (tx_done_w),
    .rx_done      (rx_done_w),
    .rx_inhibit   (rx_inhibit_w),
    .status       (irq_status_w),
    .tx_len_phase (tx_len_phase_w)
);

// File: tb/radio_fbuf_bench.sv
`timescale 1ns/1ps
module radio_fbuf_bench;

    logic       clk;
    logic       rst;
    logic       host_wr;
    logic       host_rd;
    logic [9:0] host_addr;
    logic [7:0] host_wdata;
    logic [7:0] host_rdata;
    logic       tx_valid;
    logic       tx_ready;
    logic [7:0] tx_data;
    logic       tx_last;
    logic       tx_ackreq;
    logic       rx_valid;
    logic [7:0] rx_data;
    logic       irq_n;

    int checks = 0;
    int errors = 0;

    logic [7:0] got [0:255];
    int         got_n;
    int         last_at;
    int         last_count;
    logic       ack_seen;

    radio_fbuf u_radio_fbuf (
        .clk        (clk),
        .rst        (rst),
        .host_wr    (host_wr),
        .host_rd    (host_rd),
        .host_addr  (host_addr),
        .host_wdata (host_wdata),
        .host_rdata (host_rdata),
        .tx_valid   (tx_valid),
        .tx_ready   (tx_ready),
        .tx_data    (tx_data),
        .tx_last    (tx_last),
        .tx_ackreq  (tx_ackreq),
        .rx_valid   (rx_valid),
        .rx_data    (rx_data),
        .irq_n      (irq_n)
    );

    initial clk = 1'b0;
    always #10 clk = ~clk;

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
        end
    endtask

    task automatic host_write(input int addr, input int data);
        @(negedge clk);
        host_wr    = 1'b1;
        host_addr  = 10'(addr);
        host_wdata = 8'(data);
        @(negedge clk);
        host_wr    = 1'b0;
    endtask

    task automatic host_read(input int addr, output logic [7:0] v);
        @(negedge clk);
        host_rd   = 1'b1;
        host_addr = 10'(addr);
        @(negedge clk);
        host_rd   = 1'b0;
        v = host_rdata;
    endtask

    task automatic read_chk(input string req, input int addr, input int exp);
        logic [7:0] v;
        host_read(addr, v);
        chk(req, int'(v), exp);
    endtask

    task automatic rx_byte(input int d);
        @(negedge clk);
        rx_valid = 1'b1;
        rx_data  = 8'(d);
    endtask

    task automatic rx_stop();
        @(negedge clk);
        rx_valid = 1'b0;
    endtask

    task automatic rx_frame(input int len, input int base, input int lqi, input int rssi);
        rx_byte(len);
        for (int i = 0; i < len; i++) rx_byte((base + i) & 8'hFF);
        rx_byte(lqi);
        rx_byte(rssi);
        rx_stop();
    endtask

    task automatic tx_collect(input bit stall);
        bit phase = 1'b0;
        bit done  = 1'b0;
        int guard = 0;
        got_n = 0; last_at = -1; last_count = 0; ack_seen = 1'b0;
        while (!done && guard < 1000) begin
            @(negedge clk);
            guard++;
            tx_ready = stall ? phase : 1'b1;
            phase = !phase;
            if (tx_valid && tx_ready) begin
                if (got_n == 0) ack_seen = tx_ackreq;
                got[got_n] = tx_data;
                if (tx_last) begin
                    last_at = got_n;
                    last_count++;
                    done = 1'b1;
                end
                got_n++;
            end
        end
        @(negedge clk);
        tx_ready = 1'b0;
    endtask

    task automatic t_reset();
        chk("R1 irq_n", int'(irq_n), 1);
        chk("R1 tx_valid", int'(tx_valid), 0);
        read_chk("R1 status", 12'h201, 8'h00);
        read_chk("R1 mask", 12'h202, 8'h09);
        read_chk("R1 rxctl", 12'h203, 8'h00);
    endtask

    task automatic t_txbuf_rw();
        host_write(12'h07F, 8'hA5);
        host_write(12'h000, 8'h3C);
        read_chk("R2 tx buffer top", 12'h07F, 8'hA5);
        read_chk("R2 tx buffer bottom", 12'h000, 8'h3C);
    endtask

    task automatic t_tx_basic();
        host_write(12'h202, 8'h00);
        host_write(12'h000, 8'h07);
        host_write(12'h001, 4);
        for (int i = 0; i < 4; i++) host_write(2 + i, 8'h30 + i);
        host_write(12'h200, 8'h05);
        tx_collect(1'b0);
        chk("R3 byte count", got_n, 5);
        chk("R3 length byte", int'(got[0]), 4);
        for (int i = 0; i < 4; i++) chk("R3 payload", int'(got[1 + i]), 8'h30 + i);
        chk("R3 last position", last_at, 4);
        chk("R3 ackreq", int'(ack_seen), 1);
        chk("R11 irq after tx done", int'(irq_n), 0);
        read_chk("R10 status tx done", 12'h201, 8'h01);
        chk("R11 irq after clear", int'(irq_n), 1);
        read_chk("R10 status cleared", 12'h201, 8'h00);
    endtask

    task automatic t_tx_clamp();
        host_write(12'h001, 200);
        for (int i = 2; i < 128; i++) host_write(i, i ^ 8'h5A);
        host_write(12'h200, 8'h01);
        tx_collect(1'b1);
        chk("R4 byte count", got_n, 127);
        chk("R4 length byte", int'(got[0]), 126);
        chk("R4 first payload", int'(got[1]), 2 ^ 8'h5A);
        chk("R4 final payload", int'(got[126]), 127 ^ 8'h5A);
        chk("R6 single last under stall", last_count, 1);
        chk("R3 ackreq clear", int'(ack_seen), 0);
        read_chk("R10 status clamp frame", 12'h201, 8'h01);
    endtask

    task automatic t_tx_ignored();
        host_write(12'h001, 0);
        host_write(12'h200, 8'h04);
        repeat (4) @(negedge clk);
        chk("R5 go bit clear", int'(tx_valid), 0);
        host_write(12'h200, 8'h01);
        chk("R3 zero frame valid", int'(tx_valid), 1);
        chk("R3 zero frame last", int'(tx_last), 1);
        host_write(12'h200, 8'h05);
        chk("R5 busy relaunch ack", int'(tx_ackreq), 0);
        tx_collect(1'b0);
        chk("R3 zero frame count", got_n, 1);
        chk("R3 zero frame byte", int'(got[0]), 0);
        repeat (4) @(negedge clk);
        chk("R5 busy relaunch dropped", int'(tx_valid), 0);
        read_chk("R10 status zero frame", 12'h201, 8'h01);
    endtask

    task automatic t_rx_normal();
        rx_frame(3, 8'hA0, 8'h5C, 8'hC5);
        chk("R11 irq on rx", int'(irq_n), 0);
        read_chk("R7 length", 12'h100, 3);
        for (int i = 0; i < 3; i++) read_chk("R7 payload", 12'h101 + i, 8'hA0 + i);
        read_chk("R7 lqi", 12'h104, 8'h5C);
        read_chk("R7 rssi", 12'h105, 8'hC5);
        host_write(12'h100, 8'hEE);
        read_chk("R2 rx buffer read-only", 12'h100, 3);
        read_chk("R7 status rx done", 12'h201, 8'h08);
    endtask

    task automatic t_rx_inhibit();
        host_write(12'h203, 8'h04);
        read_chk("R8 rxctl readback", 12'h203, 8'h04);
        rx_frame(2, 8'h11, 8'h22, 8'h33);
        chk("R8 irq stays high", int'(irq_n), 1);
        read_chk("R8 no status", 12'h201, 8'h00);
        read_chk("R8 length kept", 12'h100, 3);
        read_chk("R8 payload kept", 12'h101, 8'hA0);
        host_write(12'h203, 8'h00);
        rx_frame(1, 8'h77, 8'h44, 8'h55);
        read_chk("R8 resumed length", 12'h100, 1);
        read_chk("R8 resumed payload", 12'h101, 8'h77);
        read_chk("R8 resumed status", 12'h201, 8'h08);
    endtask

    task automatic t_rx_limits();
        rx_frame(141, 8'h10, 8'h6A, 8'hB6);
        read_chk("R7 max length", 12'h100, 141);
        read_chk("R7 max last payload", 12'h18D, (8'h10 + 140) & 8'hFF);
        read_chk("R7 max lqi", 12'h18E, 8'h6A);
        read_chk("R7 max rssi", 12'h18F, 8'hB6);
        read_chk("R7 max status", 12'h201, 8'h08);
        rx_frame(142, 8'h90, 8'h01, 8'h02);
        read_chk("R9 dropped status", 12'h201, 8'h00);
        read_chk("R9 buffer kept", 12'h100, 141);
        rx_frame(1, 8'hD4, 8'h03, 8'h04);
        read_chk("R9 resync length", 12'h100, 1);
        read_chk("R9 resync payload", 12'h101, 8'hD4);
        read_chk("R9 resync rssi", 12'h103, 8'h04);
        read_chk("R9 resync status", 12'h201, 8'h08);
    endtask

    task automatic t_masked();
        host_write(12'h202, 8'h09);
        rx_frame(0, 0, 8'h12, 8'h34);
        chk("R11 masked irq", int'(irq_n), 1);
        read_chk("R11 masked status", 12'h201, 8'h08);
        host_write(12'h202, 8'h00);
    endtask

    task automatic t_read_collision();
        rx_byte(0);
        rx_byte(8'h21);
        @(negedge clk);
        rx_data   = 8'h43;
        host_rd   = 1'b1;
        host_addr = 10'h201;
        @(negedge clk);
        rx_valid = 1'b0;
        host_rd  = 1'b0;
        chk("R10 read misses same-cycle event", int'(host_rdata), 8'h00);
        chk("R10 irq after collision", int'(irq_n), 0);
        read_chk("R10 event kept", 12'h201, 8'h08);
    endtask

    task automatic t_dual_event();
        host_write(12'h001, 0);
        host_write(12'h200, 8'h01);
        rx_byte(0);
        rx_byte(8'h65);
        @(negedge clk);
        rx_data  = 8'h87;
        tx_ready = 1'b1;
        @(negedge clk);
        rx_valid = 1'b0;
        tx_ready = 1'b0;
        chk("R3 dual tx finished", int'(tx_valid), 0);
        read_chk("R7 dual status", 12'h201, 8'h09);
        read_chk("R7 dual rssi", 12'h102, 8'h87);
    endtask

    initial begin
        rst = 1'b1; host_wr = 1'b0; host_rd = 1'b0; host_addr = '0; host_wdata = '0;
        tx_ready = 1'b0; rx_valid = 1'b0; rx_data = '0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        t_reset();
        t_txbuf_rw();
        t_tx_basic();
        t_tx_clamp();
        t_tx_ignored();
        t_rx_normal();
        t_rx_inhibit();
        t_rx_limits();
        t_masked();
        t_read_collision();
        t_dual_event();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule